// File: doc/BRIEF.md
# Eight-bit microcoded accumulator CPU

This block is a very small accumulator computer. Every unit shares one 8-bit bus: the program counter, memory address register, instruction register, A and B registers, adder/subtractor, output register and a 16-byte RAM. A microcoded control unit sequences the transfers. All state lives in a single clock domain. Nothing happens unless the one-cycle execution enable `step_en` is high.

Each microstep uses two enable pulses. On the first pulse, the transfer phase, the selected source drives the bus and the selected registers capture it. On the second pulse, the advance phase, the control unit moves to its next microstep. This keeps a register-capture phase and an opposite control phase without a derived clock.

An external loader can write RAM through its own port while `load_en` holds the CPU. At power-up the RAM already holds a short demo program.

Top module: `acc8_core`

## Requirements
- R1: A synchronous active-high `rst` clears the following: `out_val`, `addr_obs`, `bus_obs`, `halted`, the program counter, the microstep, the phase, the flags and the A, B and instruction registers. RAM contents are not changed, so a program in RAM runs again, and gives the same result, after a reset.
- R2: At power-up the RAM holds a demo program. It loads A from address 14 (value 28), adds address 15 (value 14), outputs the result and halts. From reset it gives `out_val` = 42 and `halted` goes high on the 31st execution enable.
- R3: An instruction byte holds the opcode in bits 7:4 and the operand or address in bits 3:0. Every instruction starts with two fetch microsteps. The enable-pulse pattern for each microstep is as follows:
  - Pulse 1 of a microstep is its transfer phase and pulse 2 is its advance phase.
  - After pulse 1 of step 0, `bus_obs` shows the program counter (zero-extended).
  - After pulse 1 of step 1, `bus_obs` shows the fetched instruction byte.
  - While `step_en` is low, no state changes.
- R4: The data instructions behave as follows:
  - LDA (0x1) loads A from RAM[operand].
  - STA (0x4) writes A to RAM[operand].
  - LDI (0x5) loads A with the zero-extended operand.
  - OUT (0xE) copies A to `out_val`.
- R5: ADD (0x2) and SUB (0x3) load B from RAM[operand] and write A+B or A−B (mod 256) into A. Carry is bit 8 of A+B, or of A+(~B)+1, so carry = 1 means no borrow. Zero is set when the result is 0. The flags are captured in microstep 4, one step before A is written in microstep 5, giving six microsteps in total.
- R6: JMP (0x6) loads the program counter with the operand. JC (0x7) does so only when carry is set, and JZ (0x8) only when zero is set.
- R7: Microstep counts are 4 for LDA and STA and 6 for ADD and SUB. Every other opcode takes 3. Each microstep takes two enables, and the count returns to step 0 after the last step. HLT (0xF) raises `halted` on the transfer pulse of its third microstep. The total number of enables to halt is therefore 2 × (sum of the earlier instruction steps) + 5.
- R8: `halted` stays high until reset. While it is high, further enables change no output.
- R9: Unused opcodes (0x0, 0x9 to 0xD) change no register and only advance the program counter.
- R10: While `load_en` is high, `load_we` writes `load_data` to RAM[`load_addr`] and enables are ignored. When `load_en` is low, `load_we` has no effect.
- R11: `addr_obs` shows the memory address register. `bus_obs` holds the bus value of the most recent transfer phase, which is 0 when no unit drove the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | One-cycle execution enable |
| load_en | input | 1 | Hold CPU and give RAM to the loader |
| load_we | input | 1 | Loader write strobe |
| load_addr | input | 4 | Loader RAM address |
| load_data | input | 8 | Loader RAM data |
| bus_obs | output | 8 | Bus value of the last transfer phase |
| addr_obs | output | 4 | Memory address register |
| out_val | output | 8 | Output register |
| halted | output | 1 | Halt reached, sticky until reset |

## Verification
The bench counts the enable pulses until `halted` rises, so a wrong microstep count or a step counter that fails to wrap shows up as a miscount on the first affected instruction. Flag or ALU faults change which conditional jumps are taken. They show up in `out_val`, which is checked at the end of each program. Fetch faults are visible in `bus_obs` one enable after the faulty transfer.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  localparam int OPC_W  = 4;
  localparam int STEP_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP = 4'h0, OP_LDA = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
    OP_STA = 4'h4, OP_LDI = 4'h5, OP_JMP = 4'h6, OP_JC  = 4'h7,
    OP_JZ  = 4'h8, OP_OUT = 4'hE, OP_HLT = 4'hF
  } opcode_e;

  typedef struct packed {
    logic pc_out;
    logic pc_inc;
    logic jump;
    logic mar_in;
    logic ram_out;
    logic ram_in;
    logic opd_out;
    logic ir_in;
    logic a_in;
    logic a_out;
    logic b_in;
    logic alu_out;
    logic alu_sub;
    logic flag_in;
    logic out_in;
    logic hlt;
    logic last;
  } ctrl_t;
endpackage

// File: rtl/acc8_ram.sv
module acc8_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import acc8_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OPD_W = DATA_W - OPC_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Power-up image: A = mem[top-1]; A += mem[top]; OUT; HLT
  function automatic logic [DATA_W-1:0] demo_byte(input int idx);
    logic [DATA_W-1:0] v;
    v = '0;
    if (idx == 0)       v = {OP_LDA, OPD_W'(DEPTH - 2)};
    else if (idx == 1)  v = {OP_ADD, OPD_W'(DEPTH - 1)};
    else if (idx == 2)  v = {OP_OUT, OPD_W'(0)};
    else if (idx == 3)  v = {OP_HLT, OPD_W'(0)};
    else if (idx == DEPTH - 2) v = DATA_W'(28);
    else if (idx == DEPTH - 1) v = DATA_W'(14);
    return v;
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = demo_byte(i);
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
  end

  assign res  = sum[DATA_W-1:0];
  assign cout = sum[DATA_W];
endmodule

// File: rtl/acc8_ctrl.sv
module acc8_ctrl
  import acc8_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [OPC_W-1:0]    op_bits,
  input  logic                flag_c,
  input  logic                flag_z,
  output ctrl_t               cw,
  output logic                xfer,
  output logic [STEP_W-1:0]   step_q
);
  logic    phase_q;
  logic    adv;
  opcode_e op;

  assign op   = opcode_e'(op_bits);
  assign xfer = go & ~phase_q;
  assign adv  = go &  phase_q;

  always_comb begin
    cw = '0;
    if (step_q == 3'd0) begin
      cw.pc_out = 1'b1;
      cw.mar_in = 1'b1;
    end else if (step_q == 3'd1) begin
      cw.ram_out = 1'b1;
      cw.ir_in   = 1'b1;
      cw.pc_inc  = 1'b1;
    end else begin
      unique case (op)
        OP_LDA, OP_STA: begin
          if (step_q == 3'd2) begin
            cw.opd_out = 1'b1;
            cw.mar_in  = 1'b1;
          end else begin
            cw.last = 1'b1;
            if (op == OP_LDA) begin
              cw.ram_out = 1'b1;
              cw.a_in    = 1'b1;
            end else begin
              cw.a_out  = 1'b1;
              cw.ram_in = 1'b1;
            end
          end
        end
        OP_ADD, OP_SUB: begin
          cw.alu_sub = (op == OP_SUB);
          unique case (step_q)
            3'd2: begin cw.opd_out = 1'b1; cw.mar_in = 1'b1; end
            3'd3: begin cw.ram_out = 1'b1; cw.b_in = 1'b1; end
            3'd4: cw.flag_in = 1'b1;
            default: begin cw.alu_out = 1'b1; cw.a_in = 1'b1; cw.last = 1'b1; end
          endcase
        end
        OP_LDI: begin cw.opd_out = 1'b1; cw.a_in = 1'b1; cw.last = 1'b1; end
        OP_JMP: begin cw.opd_out = 1'b1; cw.jump = 1'b1; cw.last = 1'b1; end
        OP_JC:  begin cw.opd_out = flag_c; cw.jump = flag_c; cw.last = 1'b1; end
        OP_JZ:  begin cw.opd_out = flag_z; cw.jump = flag_z; cw.last = 1'b1; end
        OP_OUT: begin cw.a_out = 1'b1; cw.out_in = 1'b1; cw.last = 1'b1; end
        OP_HLT: begin cw.hlt = 1'b1; cw.last = 1'b1; end
        default: cw.last = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      step_q  <= '0;
    end else if (go) begin
      phase_q <= ~phase_q;
      if (adv) step_q <= cw.last ? '0 : step_q + 1'b1;
    end
  end
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              load_en,
  input  logic              load_we,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] bus_obs,
  output logic [ADDR_W-1:0] addr_obs,
  output logic [DATA_W-1:0] out_val,
  output logic              halted
);
  localparam int OPD_W = DATA_W - OPC_W;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, a_q, b_q, out_q, bus_q;
  logic              c_q, z_q, halt_q;
  logic [DATA_W-1:0] bus, ram_rd, alu_res;
  logic              alu_cout;
  logic              go, xfer;
  ctrl_t             cw;
  logic [STEP_W-1:0] step_q;

  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wd;

  assign go = step_en & ~load_en & ~halt_q;

  acc8_ctrl u_ctrl (
    .clk(clk), .rst(rst), .go(go),
    .op_bits(ir_q[DATA_W-1 -: OPC_W]),
    .flag_c(c_q), .flag_z(z_q),
    .cw(cw), .xfer(xfer), .step_q(step_q)
  );

  acc8_alu #(.DATA_W(DATA_W)) u_alu (
    .a(a_q), .b(b_q), .sub(cw.alu_sub), .res(alu_res), .cout(alu_cout)
  );

  always_comb begin
    if (load_en) begin
      ram_we   = load_we;
      ram_addr = load_addr;
      ram_wd   = load_data;
    end else begin
      ram_we   = xfer & cw.ram_in;
      ram_addr = mar_q;
      ram_wd   = bus;
    end
  end

  acc8_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wd), .rdata(ram_rd)
  );

  // shared bus: at most one source per microstep
  always_comb begin
    bus = '0;
    if (cw.pc_out)       bus = DATA_W'(pc_q);
    else if (cw.ram_out) bus = ram_rd;
    else if (cw.opd_out) bus = DATA_W'(ir_q[OPD_W-1:0]);
    else if (cw.a_out)   bus = a_q;
    else if (cw.alu_out) bus = alu_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      mar_q  <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      out_q  <= '0;
      bus_q  <= '0;
      c_q    <= 1'b0;
      z_q    <= 1'b0;
      halt_q <= 1'b0;
    end else if (xfer) begin
      bus_q <= bus;
      if (cw.mar_in) mar_q <= bus[ADDR_W-1:0];
      if (cw.ir_in)  ir_q  <= bus;
      if (cw.a_in)   a_q   <= bus;
      if (cw.b_in)   b_q   <= bus;
      if (cw.out_in) out_q <= bus;
      if (cw.pc_inc) pc_q  <= pc_q + 1'b1;
      else if (cw.jump) pc_q <= bus[ADDR_W-1:0];
      if (cw.flag_in) begin
        c_q <= alu_cout;
        z_q <= (alu_res == '0);
      end
      if (cw.hlt) halt_q <= 1'b1;
    end
  end

  assign bus_obs  = bus_q;
  assign addr_obs = mar_q;
  assign out_val  = out_q;
  assign halted   = halt_q;
endmodule

// File: rtl/acc8_checker.sv
module acc8_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              step_en,
  input logic              load_en,
  input logic              halted,
  input logic [DATA_W-1:0] out_val,
  input logic [ADDR_W-1:0] addr_obs,
  input logic [DATA_W-1:0] bus_obs,
  input logic [STEP_W-1:0] step_q,
  input logic              alu_wr,
  input logic              xfer,
  input logic              flag_z,
  input logic              flag_c,
  input logic [DATA_W-1:0] alu_res,
  input logic              alu_cout
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (out_val == '0 && !halted && step_q == '0 && bus_obs == '0 && addr_obs == '0));

  p_step_range_r7: assert property (@(posedge clk) disable iff (rst)
    step_q <= STEP_W'(5));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(step_q) && $stable(bus_obs) && $stable(out_val) && $stable(addr_obs)));

  p_flags_before_a_r5: assert property (@(posedge clk) disable iff (rst)
    (xfer && alu_wr) |-> (flag_z == (alu_res == '0) && flag_c == alu_cout));

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(out_val) && $stable(bus_obs) && $stable(addr_obs)));

  p_load_hold_r10: assert property (@(posedge clk) disable iff (rst)
    load_en |=> ($stable(step_q) && $stable(out_val) && $stable(bus_obs) && $stable(addr_obs)));
endmodule

bind acc8_core acc8_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEP_W(acc8_pkg::STEP_W)) u_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .load_en(load_en),
  .halted(halted), .out_val(out_val), .addr_obs(addr_obs), .bus_obs(bus_obs),
  .step_q(step_q), .alu_wr(cw.a_in && cw.alu_out), .xfer(xfer),
  .flag_z(z_q), .flag_c(c_q), .alu_res(alu_res), .alu_cout(alu_cout)
);

// File: tb/acc8_core_test.sv
`timescale 1ns/1ps
module acc8_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic       load_en = 1'b0;
  logic       load_we = 1'b0;
  logic [3:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic [7:0] bus_obs, out_val;
  logic [3:0] addr_obs;
  logic       halted;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] prog [16];

  always #2 clk = ~clk;

  acc8_core uut (
    .clk(clk), .rst(rst), .step_en(step_en), .load_en(load_en),
    .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
    .bus_obs(bus_obs), .addr_obs(addr_obs), .out_val(out_val), .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk) step_en = 1'b1;
    @(negedge clk) step_en = 1'b0;
  endtask

  task automatic load_prog();
    @(negedge clk) load_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      load_addr = 4'(i);
      load_data = prog[i];
      load_we   = 1'b1;
      @(negedge clk);
    end
    load_we = 1'b0;
    load_en = 1'b0;
  endtask

  task automatic run_to_halt(input int start, input int limit, output int n);
    n = start;
    while (!halted && n < limit) begin
      pulse();
      n++;
    end
  endtask

  // instruction-level reference: output value and enables to halt
  task automatic model(output logic [7:0] o, output int en, output bit ok);
    logic [7:0] m [16];
    logic [3:0] pc;
    logic [7:0] a, b, ir, r;
    logic [8:0] s;
    logic       c, z;
    int         steps;
    for (int i = 0; i < 16; i++) m[i] = prog[i];
    pc = 0; a = 0; b = 0; c = 0; z = 0; o = 0; en = 0; ok = 0;
    for (int k = 0; k < 40; k++) begin
      ir = m[pc];
      pc = pc + 1'b1;
      steps = 3;
      case (ir[7:4])
        4'h1: begin a = m[ir[3:0]]; steps = 4; end
        4'h2, 4'h3: begin
          b = m[ir[3:0]];
          if (ir[7:4] == 4'h2) s = {1'b0, a} + {1'b0, b};
          else                 s = {1'b0, a} + {1'b0, ~b} + 9'd1;
          r = s[7:0]; c = s[8]; z = (r == 8'd0); a = r; steps = 6;
        end
        4'h4: begin m[ir[3:0]] = a; steps = 4; end
        4'h5: a = {4'h0, ir[3:0]};
        4'h6: pc = ir[3:0];
        4'h7: if (c) pc = ir[3:0];
        4'h8: if (z) pc = ir[3:0];
        4'hE: o = a;
        4'hF: begin en = en + 5; ok = 1; return; end
        default: ;
      endcase
      en = en + 2 * steps;
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = 8'h00;
  endtask

  task automatic run_directed(input string req, input string name, input logic [7:0] exp_out);
    logic [7:0] mo; int me, n; bit ok;
    model(mo, me, ok);
    load_prog();
    do_reset();
    run_to_halt(0, me + 4, n);
    chk(n == me, "R7", {name, " enables to halt"}, n, me);
    chk(out_val == exp_out, req, {name, " output"}, out_val, exp_out);
    chk(halted == 1'b1, "R7", {name, " halted"}, halted, 1);
  endtask

  initial begin : wd
    for (int cyc = 0; cyc < 190000; cyc++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] mo, snap_out; logic [3:0] snap_addr; int me, n, rnd; bit ok;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(out_val == 0 && bus_obs == 0 && addr_obs == 0, "R1", "reset outputs", out_val, 0);
    chk(halted == 0, "R1", "reset halted", halted, 0);

    // R10: enables ignored under load_en
    @(negedge clk) load_en = 1'b1;
    repeat (3) pulse();
    @(negedge clk) load_en = 1'b0;
    chk(bus_obs == 0 && addr_obs == 0, "R10", "held bus", bus_obs, 0);

    // R2 demo
    run_to_halt(0, 40, n);
    chk(n == 31, "R2", "demo enables", n, 31);
    chk(out_val == 42, "R2", "demo output", out_val, 42);
    chk(addr_obs == 3, "R11", "addr after halt", addr_obs, 3);
    chk(bus_obs == 0, "R11", "idle bus after halt", bus_obs, 0);

    // R8 sticky halt
    snap_out = out_val; snap_addr = addr_obs;
    repeat (6) pulse();
    chk(halted == 1 && out_val == snap_out && addr_obs == snap_addr, "R8",
        "frozen after halt", out_val, snap_out);

    // R10 write without load_en ignored; R1 RAM kept over reset
    @(negedge clk) begin load_we = 1'b1; load_addr = 4'd15; load_data = 8'd99; end
    @(negedge clk) load_we = 1'b0;
    do_reset();
    chk(halted == 0 && out_val == 0, "R1", "halt cleared", halted, 0);
    run_to_halt(0, 40, n);
    chk(out_val == 42 && n == 31, "R1", "demo rerun after reset", out_val, 42);

    // R3 fetch visibility, R4 LDI, R5 ADD
    clear_prog();
    prog[0] = 8'h55; prog[1] = 8'h2F; prog[2] = 8'hE0; prog[3] = 8'hF0; prog[15] = 8'd7;
    load_prog();
    do_reset();
    pulse();
    chk(bus_obs == 8'h00 && addr_obs == 0, "R3", "step0 bus shows pc", bus_obs, 0);
    pulse(); pulse();
    chk(bus_obs == 8'h55, "R3", "step1 bus shows instruction", bus_obs, 8'h55);
    pulse(); pulse();
    chk(bus_obs == 8'h05, "R4", "LDI operand on bus", bus_obs, 5);
    run_to_halt(5, 40, n);
    chk(n == 29, "R5", "six-step add timing", n, 29);
    chk(out_val == 12, "R5", "add result", out_val, 12);

    // R5/R6 SUB with borrow, JC not taken
    clear_prog();
    prog[0] = 8'h53; prog[1] = 8'h3F; prog[2] = 8'h76; prog[3] = 8'hE0; prog[4] = 8'hF0;
    prog[6] = 8'h51; prog[7] = 8'hE0; prog[8] = 8'hF0; prog[15] = 8'd5;
    run_directed("R5", "sub borrow", 8'hFE);

    // R5/R6 SUB to zero, JZ taken
    clear_prog();
    prog[0] = 8'h55; prog[1] = 8'h3F; prog[2] = 8'h85; prog[3] = 8'hE0; prog[4] = 8'hF0;
    prog[5] = 8'h5C; prog[6] = 8'hE0; prog[7] = 8'hF0; prog[15] = 8'd5;
    run_directed("R6", "jz taken", 8'h0C);

    // R5/R6 ADD carry, JC taken
    clear_prog();
    prog[0] = 8'h1E; prog[1] = 8'h2F; prog[2] = 8'h75; prog[3] = 8'h50; prog[4] = 8'hE0;
    prog[5] = 8'hE0; prog[6] = 8'hF0; prog[14] = 8'd200; prog[15] = 8'd100;
    run_directed("R6", "jc taken after carry", 8'd44);

    // R4 STA then LDA
    clear_prog();
    prog[0] = 8'h59; prog[1] = 8'h4E; prog[2] = 8'h50; prog[3] = 8'h1E; prog[4] = 8'h2E;
    prog[5] = 8'hE0; prog[6] = 8'hF0;
    run_directed("R4", "store and reload", 8'd18);

    // R6 JMP
    clear_prog();
    prog[0] = 8'h63; prog[1] = 8'h57; prog[2] = 8'hE0; prog[3] = 8'h52; prog[4] = 8'hE0; prog[5] = 8'hF0;
    run_directed("R6", "jmp", 8'd2);

    // R9 unused opcodes
    clear_prog();
    prog[0] = 8'h59; prog[1] = 8'h90; prog[2] = 8'h00; prog[3] = 8'hA3; prog[4] = 8'hDF;
    prog[5] = 8'hE0; prog[6] = 8'hF0;
    run_directed("R9", "no-op opcodes", 8'd9);

    // random programs
    for (int t = 0; t < 30; t++) begin
      for (int i = 0; i < 16; i++) begin
        rnd = $urandom_range(0, 12);
        case (rnd)
          0: prog[i] = {4'h1, 4'($urandom)};
          1, 2: prog[i] = {4'h2, 4'($urandom)};
          3, 4: prog[i] = {4'h3, 4'($urandom)};
          5: prog[i] = {4'h4, 4'($urandom_range(8, 15))};
          6: prog[i] = {4'h5, 4'($urandom)};
          7: prog[i] = {4'h7, 4'($urandom)};
          8: prog[i] = {4'h8, 4'($urandom)};
          9, 10: prog[i] = 8'hE0;
          11: prog[i] = 8'hF0;
          default: prog[i] = 8'($urandom);
        endcase
      end
      model(mo, me, ok);
      if (ok) begin
        load_prog();
        do_reset();
        run_to_halt(0, me + 4, n);
        chk(n == me, "R7", "random enables to halt", n, me);
        chk(out_val == mo, "R5", "random program output", out_val, mo);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule